// File: doc/BRIEF.md
# Segmented DAC Switch Decoder

This block turns an unsigned digital sample into the switch-control pattern of a segmented current-steering converter array. On every rising clock edge it captures the sample. It splits the sample into three fields. The upper field selects how many of a bank of equal coarse unit sources are on. The middle field does the same for a bank of finer sub-unit sources. The lowest bits drive binary-weighted sources directly.

Every source has a pair of controls. The A control steers the source to the first output node and the B control steers it to the complementary node. The A side therefore carries the weight of the sample and the B side carries the weight of its ones' complement.

All decoded controls leave the block from one final register bank, so every switch in the array changes on the same clock edge. A new sample can be accepted on every cycle. The analog sources, the reference and the full-scale setting are outside this block.

Top module: `seg_dac_decoder`

## Requirements
- R1: A code presented on `code_i` before rising edge k appears on the switch outputs just after rising edge k+1 (two-cycle latency), and the previous decode stays on the outputs after edge k.
- R2: Coarse control `upper_a_o[i]` (i = 0..30) is 1 exactly when the coarse field `code_i[11:7]` is greater than i.
- R3: Fine control `mid_a_o[j]` (j = 0..14) is 1 exactly when the fine field `code_i[6:3]` is greater than j.
- R4: `lsb_a_o` equals `code_i[2:0]`, and bit k carries a weight of 2^k units.
- R5: Every B output is the exact bitwise inverse of its A partner, so each source is steered to exactly one node.
- R6: The A weight, (ones in `upper_a_o`)×128 + (ones in `mid_a_o`)×8 + `lsb_a_o`, equals the code for all 4096 codes. The B weight, computed the same way from the B outputs, equals 4095 − code.
- R7: Code 4095 sets every A output to 1 and every B output to 0. Code 0 sets every A output to 0 and every B output to 1.
- R8: While `rst_ni` is low, and after it rises until a new code has passed through the pipeline, all A outputs are 0 and all B outputs are 1.
- R9: Codes that change on every cycle appear on consecutive cycles in the same order, one per cycle, with no sample lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 12 | Unsigned sample code |
| upper_a_o | output | 31 | Coarse unit controls, steer to node A |
| upper_b_o | output | 31 | Coarse unit controls, steer to node B |
| mid_a_o | output | 15 | Fine unit controls, steer to node A |
| mid_b_o | output | 15 | Fine unit controls, steer to node B |
| lsb_a_o | output | 3 | Binary-weighted controls, steer to node A |
| lsb_b_o | output | 3 | Binary-weighted controls, steer to node B |

## Verification
The hardest situations to reach are the field roll-overs, where one coarse unit must replace exactly fifteen fine units plus seven binary units between two adjacent codes. An error there leaves the weight off by one step at a single code only. The bench therefore streams all 4096 codes in order, one per cycle, and checks the A and B weights, the thermometer patterns and the complement on every sample. It adds back-to-back jumps between the extremes and across roll-over boundaries, and it asserts reset in the middle of a stream.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  parameter int unsigned CODE_W  = 12;
  parameter int unsigned UPPER_W = 5;
  parameter int unsigned MID_W   = 4;
  parameter int unsigned LSB_W   = CODE_W - UPPER_W - MID_W;
  parameter int unsigned UPPER_N = (1 << UPPER_W) - 1;
  parameter int unsigned MID_N   = (1 << MID_W) - 1;
endpackage

// File: rtl/sdd_capture.sv
module sdd_capture #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/sdd_thermo.sv
// Field-to-thermometer: bit i set when field > i; REVERSE mirrors bit order.
module sdd_thermo #(
  parameter int unsigned IN_W    = 5,
  parameter bit          REVERSE = 1'b0,
  localparam int unsigned N      = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0] field_i,
  output logic [N-1:0]    therm_o
);
  for (genvar i = 0; i < N; i++) begin : g_seg
    if (REVERSE) begin : g_rev
      assign therm_o[N-1-i] = (field_i > IN_W'(i));
    end else begin : g_fwd
      assign therm_o[i] = (field_i > IN_W'(i));
    end
  end
endmodule

// File: rtl/sdd_out_reg.sv
module sdd_out_reg #(
  parameter int unsigned W = 49
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  // reset state: every source on node B
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o <= '0;
      b_o <= '1;
    end else begin
      a_o <= a_i;
      b_o <= b_i;
    end
  end
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import seg_dac_pkg::*;
#(
  parameter int unsigned CW = CODE_W,
  parameter int unsigned UW = UPPER_W,
  parameter int unsigned MW = MID_W,
  localparam int unsigned LW = CW - UW - MW,
  localparam int unsigned UN = (1 << UW) - 1,
  localparam int unsigned MN = (1 << MW) - 1,
  localparam int unsigned SW = UN + MN + LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] code_i,
  output logic [UN-1:0] upper_a_o,
  output logic [UN-1:0] upper_b_o,
  output logic [MN-1:0] mid_a_o,
  output logic [MN-1:0] mid_b_o,
  output logic [LW-1:0] lsb_a_o,
  output logic [LW-1:0] lsb_b_o
);
  logic [CW-1:0] code_q;
  logic [CW-1:0] code_n;
  logic [UN-1:0] up_a, up_b;
  logic [MN-1:0] md_a, md_b;
  logic [SW-1:0] sw_a, sw_b, sw_a_q, sw_b_q;

  sdd_capture #(.W(CW)) u_capture (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (code_i),
    .q_o   (code_q)
  );

  // B side decodes the ones' complement so the pair is built independently
  assign code_n = ~code_q;

  sdd_thermo #(.IN_W(UW), .REVERSE(1'b0)) u_up_a (
    .field_i(code_q[CW-1 -: UW]), .therm_o(up_a));
  sdd_thermo #(.IN_W(UW), .REVERSE(1'b1)) u_up_b (
    .field_i(code_n[CW-1 -: UW]), .therm_o(up_b));
  sdd_thermo #(.IN_W(MW), .REVERSE(1'b0)) u_md_a (
    .field_i(code_q[LW +: MW]), .therm_o(md_a));
  sdd_thermo #(.IN_W(MW), .REVERSE(1'b1)) u_md_b (
    .field_i(code_n[LW +: MW]), .therm_o(md_b));

  assign sw_a = {up_a, md_a, code_q[LW-1:0]};
  assign sw_b = {up_b, md_b, code_n[LW-1:0]};

  sdd_out_reg #(.W(SW)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (sw_a),
    .b_i   (sw_b),
    .a_o   (sw_a_q),
    .b_o   (sw_b_q)
  );

  assign {upper_a_o, mid_a_o, lsb_a_o} = sw_a_q;
  assign {upper_b_o, mid_b_o, lsb_b_o} = sw_b_q;

  // ---------------- assertions ----------------
  localparam int unsigned UNIT_U = 1 << (CW - UW);
  localparam int unsigned UNIT_M = 1 << LW;

  AST_PAIR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_a_q ^ sw_b_q) == '1); // R5

  AST_UPPER_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((upper_a_o & (upper_a_o + UN'(1))) == '0)); // R2

  AST_MID_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mid_a_o & (mid_a_o + MN'(1))) == '0)); // R3

  AST_WEIGHT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'($countones(upper_a_o)) * UNIT_U + 32'($countones(mid_a_o)) * UNIT_M
       + 32'(lsb_a_o)) == 32'($past(code_q))); // R6

  AST_LSB_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsb_a_o == $past(code_q[LW-1:0])); // R4
endmodule

// File: tb/seg_dac_decoder_bench.sv
`timescale 1ns/1ps
module seg_dac_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] code_i = '0;
  logic [30:0] upper_a_o, upper_b_o;
  logic [14:0] mid_a_o, mid_b_o;
  logic [2:0]  lsb_a_o, lsb_b_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  seg_dac_decoder u_seg_dac_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_i),
    .upper_a_o(upper_a_o), .upper_b_o(upper_b_o),
    .mid_a_o(mid_a_o), .mid_b_o(mid_b_o),
    .lsb_a_o(lsb_a_o), .lsb_b_o(lsb_b_o)
  );

  task automatic expect_code(input int c, input string tag);
    logic [30:0] eu;
    logic [14:0] em;
    logic [2:0]  el;
    int wa, wb;
    eu = 31'((64'd1 << (c >> 7)) - 1);
    em = 15'(((c >> 3) & 15) == 0 ? 0 : (1 << ((c >> 3) & 15)) - 1);
    el = 3'(c & 7);
    wa = $countones(upper_a_o) * 128 + $countones(mid_a_o) * 8 + int'(lsb_a_o);
    wb = $countones(upper_b_o) * 128 + $countones(mid_b_o) * 8 + int'(lsb_b_o);
    checks++;
    if (upper_a_o !== eu || mid_a_o !== em || lsb_a_o !== el) begin
      failures++;
      $display("FAIL %s code=%0d A: upper=%h mid=%h lsb=%0d expected upper=%h mid=%h lsb=%0d",
               tag, c, upper_a_o, mid_a_o, lsb_a_o, eu, em, el);
    end
    checks++;
    if (upper_b_o !== ~eu || mid_b_o !== ~em || lsb_b_o !== ~el) begin
      failures++;
      $display("FAIL R5 code=%0d B: upper=%h mid=%h lsb=%0d expected upper=%h mid=%h lsb=%0d",
               c, upper_b_o, mid_b_o, lsb_b_o, ~eu, ~em, ~el);
    end
    checks++;
    if (wa != c || wb != 4095 - c) begin
      failures++;
      $display("FAIL R6 code=%0d weights A=%0d B=%0d expected A=%0d B=%0d",
               c, wa, wb, c, 4095 - c);
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk_i);
    expect_code(0, "R8 during reset");
    rst_ni = 1'b1;
    code_i = 12'd0;
    @(negedge clk_i);
    expect_code(0, "R8 after release");
  endtask

  task automatic t_latency;
    @(negedge clk_i); code_i = 12'd1000;
    @(negedge clk_i); code_i = 12'd1000;
    expect_code(0, "R1 one edge: old value held");
    @(negedge clk_i);
    expect_code(1000, "R1 two edges");
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 4098; n++) begin
      @(negedge clk_i);
      if (n >= 2) expect_code(n - 2, "R2/R3/R4 sweep");
      if (n < 4096) code_i = 12'(n);
    end
  endtask

  task automatic t_extremes;
    int seq[8] = '{4095, 0, 4095, 127, 128, 2047, 2048, 0};
    for (int n = 0; n < 10; n++) begin
      @(negedge clk_i);
      if (n >= 2) expect_code(seq[n-2], "R7/R9 back-to-back");
      if (n < 8) code_i = 12'(seq[n]);
    end
  endtask

  task automatic t_mid_reset;
    @(negedge clk_i); code_i = 12'd3333;
    @(negedge clk_i);
    @(negedge clk_i);
    expect_code(3333, "R1 before reset");
    #1 rst_ni = 1'b0;
    #1 expect_code(0, "R8 async reset");
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    expect_code(0, "R8 held after release");
    @(negedge clk_i);
    expect_code(3333, "R1 refill after reset");
  endtask

  initial begin
    rst_ni = 1'b0;
    code_i = 12'd0;
    t_reset_state();
    t_latency();
    t_sweep();
    t_extremes();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule